// File: doc/BRIEF.md
# GPIO Port Controller with Staged Shadow Commit

The block controls four ports of 32 general-purpose pins each. Every pin carries five configuration bits: interrupt enable, mask, two pattern bits and a pull enable. The mode of a pin comes from the interrupt, mask and pattern bits read together. The pin can be handed to one of four device functions, driven as a plain output, read as a plain input, or armed as a level or single-edge interrupt source. Inputs pass through a two-flop synchronizer. A sticky flag per pin records each armed event. Each port raises one interrupt line for the flags that are enabled.

Software reaches the block through a flat register interface. The write address holds a port number, a field selector and an operation. An operation either ORs the data into a field or clears the bits the data names, so a pin changes without disturbing its neighbours. A fifth port number (7) reaches a shadow configuration bank. A single load write copies that bank into any subset of one real port's pins on one clock edge, so a multi-pin reconfiguration never shows a half-applied state.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin is an input with pull enabled. Mask, pattern-1 and pull read as all ones, interrupt, pattern-0 and flag read as zero, no pad is driven and every port interrupt is low.
- R2: A pin with interrupt=0 and mask=0 is routed to device function f={pattern1,pattern0}. Its pad drive and output enable come from dev_do/dev_oe bit f*128 + port*32 + pin.
- R3: A pin with interrupt=0, mask=1 and pattern1=0 is an output. Output enable is 1 and the pad value equals pattern0.
- R4: A pin with interrupt=1, or with mask=1 and pattern1=1, is not driven (pad_oe=0, pad_do=0). pad_pu follows the pull bit in every mode.
- R5: A write address is {port[7:5], field[4:2], op[1:0]}. The fields are 0 interrupt, 1 mask, 2 pattern1, 3 pattern0, 4 pull, 5 flag, 6 level and 7 load. Op 1 ORs the data into the field, op 2 clears the bits set in the data, and ops 0 and 3 change nothing. Pins outside the data are untouched.
- R6: A read of field 6 returns the port's pad inputs after a two-flop synchronizer, so a change appears on the second clock edge. Writes to field 6 have no effect.
- R7: Port 7 holds shadow copies of fields 0 to 4. A write to {7, field 7, target port} copies the shadow bits into the pins of the target port set in the data, all on one edge. Other pins, other ports and the shadow bank are unchanged. A 5-bit code c maps to pull=c[4], interrupt=c[3], mask=c[2], pattern1=c[1], pattern0=c[0].
- R8: With interrupt=1 and pattern1=0, the pin's flag is set on every cycle in which the synchronized input equals pattern0.
- R9: With interrupt=1 and pattern1=1, the flag is set only when the synchronized input changes to the value of pattern0. The opposite transition sets nothing.
- R10: Flags are sticky. A write with op 2 to field 5 clears the named flags, and op 1 on field 5 is ignored. If a flag's set condition holds in the same cycle as its clear, the flag stays set.
- R11: port_irq[p] is high exactly when some pin of port p has its flag set, interrupt=1 and mask=0.
- R12: Port numbers 4 to 6 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address {port, field, op} |
| wr_data | input | 32 | Write data or pin mask |
| rd_addr | input | 8 | Read address {port, field, ignored} |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pad_di | input | 128 | Pad input levels, port-major |
| pad_do | output | 128 | Pad output levels |
| pad_oe | output | 128 | Pad output enables |
| pad_pu | output | 128 | Pad pull enables |
| dev_do | input | 512 | Device function output levels, function-major |
| dev_oe | input | 512 | Device function output enables, function-major |
| port_irq | output | 4 | Combined interrupt per port |

## Verification
Two things can land on the same flag bit in one cycle: a bus clear of the flag and the pin's own armed condition. The bench holds a level-high pin in its active state while it clears that pin's flag together with an edge pin's flag. It then checks that only the edge flag drops and that the level flag survives. A second collision is a shadow load that moves pins into interrupt mode while their inputs are static. This is judged by reading back flags and by checking that loaded pins change and unloaded pins do not.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    localparam int          ADDR_W      = 8;
    localparam int          NUM_FUNC    = 4;
    localparam logic [2:0]  SHADOW_PORT = 3'd7;

    typedef enum logic [2:0] {
        FLD_INTR  = 3'd0,
        FLD_MASK  = 3'd1,
        FLD_PAT1  = 3'd2,
        FLD_PAT0  = 3'd3,
        FLD_PULL  = 3'd4,
        FLD_FLAG  = 3'd5,
        FLD_LEVEL = 3'd6,
        FLD_LOAD  = 3'd7
    } fld_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RSVD = 2'd3
    } op_e;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = din;
        s_d.stable = s_q.meta;
        s_d.last   = s_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl = s_q.stable;
    assign prv = s_q.last;
endmodule

// File: rtl/gpio_pin_route.sv
`timescale 1ns/1ps
module gpio_pin_route
    import gpio_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic [PIN_W-1:0]                intr,
    input  logic [PIN_W-1:0]                mask,
    input  logic [PIN_W-1:0]                pat1,
    input  logic [PIN_W-1:0]                pat0,
    input  logic [NUM_FUNC-1:0][PIN_W-1:0]  dev_do,
    input  logic [NUM_FUNC-1:0][PIN_W-1:0]  dev_oe,
    output logic [PIN_W-1:0]                pad_do,
    output logic [PIN_W-1:0]                pad_oe
);
    always_comb begin
        for (int i = 0; i < PIN_W; i++) begin
            pad_do[i] = 1'b0;
            pad_oe[i] = 1'b0;
            if (!intr[i] && !mask[i]) begin
                pad_do[i] = dev_do[{pat1[i], pat0[i]}][i];
                pad_oe[i] = dev_oe[{pat1[i], pat0[i]}][i];
            end else if (!intr[i] && !pat1[i]) begin
                pad_do[i] = pat0[i];
                pad_oe[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter  int NUM_PORTS = 4,
    parameter  int PIN_W     = 32,
    localparam int TOTAL     = NUM_PORTS * PIN_W,
    localparam int DEV_W     = NUM_FUNC * TOTAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PIN_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIN_W-1:0]  rd_data,
    input  logic [TOTAL-1:0]  pad_di,
    output logic [TOTAL-1:0]  pad_do,
    output logic [TOTAL-1:0]  pad_oe,
    output logic [TOTAL-1:0]  pad_pu,
    input  logic [DEV_W-1:0]  dev_do,
    input  logic [DEV_W-1:0]  dev_oe,
    output logic [NUM_PORTS-1:0] port_irq
);
    typedef logic [NUM_PORTS-1:0][PIN_W-1:0] bank_t;

    typedef struct packed {
        bank_t            intr;
        bank_t            mask;
        bank_t            pat1;
        bank_t            pat0;
        bank_t            pull;
        bank_t            flag;
        logic [PIN_W-1:0] s_intr;
        logic [PIN_W-1:0] s_mask;
        logic [PIN_W-1:0] s_pat1;
        logic [PIN_W-1:0] s_pat0;
        logic [PIN_W-1:0] s_pull;
    } state_t;

    localparam state_t RST_STATE = '{
        intr: '0, mask: '1, pat1: '1, pat0: '0, pull: '1, flag: '0,
        s_intr: '0, s_mask: '0, s_pat1: '0, s_pat0: '0, s_pull: '0
    };

    state_t st_d, st_q;
    bank_t  lvl, prv, ev;

    logic [2:0] wport, rport;
    fld_e       wfld, rfld;
    op_e        wop;

    assign wport = wr_addr[7:5];
    assign wfld  = fld_e'(wr_addr[4:2]);
    assign wop   = op_e'(wr_addr[1:0]);
    assign rport = rd_addr[7:5];
    assign rfld  = fld_e'(rd_addr[4:2]);

    function automatic logic [PIN_W-1:0] setclr(
        input logic [PIN_W-1:0] old,
        input logic [PIN_W-1:0] d,
        input op_e              op
    );
        case (op)
            OP_SET:  setclr = old | d;
            OP_CLR:  setclr = old & ~d;
            default: setclr = old;
        endcase
    endfunction

    function automatic logic [PIN_W-1:0] merge(
        input logic [PIN_W-1:0] old,
        input logic [PIN_W-1:0] shadow,
        input logic [PIN_W-1:0] sel
    );
        merge = (old & ~sel) | (shadow & sel);
    endfunction

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [NUM_FUNC-1:0][PIN_W-1:0] dfn_do, dfn_oe;

        for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
            assign dfn_do[f] = dev_do[f*TOTAL + p*PIN_W +: PIN_W];
            assign dfn_oe[f] = dev_oe[f*TOTAL + p*PIN_W +: PIN_W];
        end

        gpio_in_sync #(.W(PIN_W)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pad_di[p*PIN_W +: PIN_W]),
            .lvl   (lvl[p]),
            .prv   (prv[p])
        );

        gpio_pin_route #(.PIN_W(PIN_W)) u_route (
            .intr   (st_q.intr[p]),
            .mask   (st_q.mask[p]),
            .pat1   (st_q.pat1[p]),
            .pat0   (st_q.pat0[p]),
            .dev_do (dfn_do),
            .dev_oe (dfn_oe),
            .pad_do (pad_do[p*PIN_W +: PIN_W]),
            .pad_oe (pad_oe[p*PIN_W +: PIN_W])
        );

        // armed condition: level match, or change that lands on the armed value
        assign ev[p] = st_q.intr[p] & ~(lvl[p] ^ st_q.pat0[p]) &
                       (~st_q.pat1[p] | (lvl[p] ^ prv[p]));

        assign pad_pu[p*PIN_W +: PIN_W] = st_q.pull[p];
        assign port_irq[p] = |(st_q.flag[p] & st_q.intr[p] & ~st_q.mask[p]);
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en && wport == 3'(p)) begin
                case (wfld)
                    FLD_INTR: st_d.intr[p] = setclr(st_q.intr[p], wr_data, wop);
                    FLD_MASK: st_d.mask[p] = setclr(st_q.mask[p], wr_data, wop);
                    FLD_PAT1: st_d.pat1[p] = setclr(st_q.pat1[p], wr_data, wop);
                    FLD_PAT0: st_d.pat0[p] = setclr(st_q.pat0[p], wr_data, wop);
                    FLD_PULL: st_d.pull[p] = setclr(st_q.pull[p], wr_data, wop);
                    FLD_FLAG: if (wop == OP_CLR) st_d.flag[p] = st_q.flag[p] & ~wr_data;
                    default: ;
                endcase
            end
            // a new event wins over a clear in the same cycle
            st_d.flag[p] = st_d.flag[p] | ev[p];
        end
        if (wr_en && wport == SHADOW_PORT) begin
            case (wfld)
                FLD_INTR: st_d.s_intr = setclr(st_q.s_intr, wr_data, wop);
                FLD_MASK: st_d.s_mask = setclr(st_q.s_mask, wr_data, wop);
                FLD_PAT1: st_d.s_pat1 = setclr(st_q.s_pat1, wr_data, wop);
                FLD_PAT0: st_d.s_pat0 = setclr(st_q.s_pat0, wr_data, wop);
                FLD_PULL: st_d.s_pull = setclr(st_q.s_pull, wr_data, wop);
                FLD_LOAD: begin
                    for (int p = 0; p < NUM_PORTS; p++) begin
                        if (wr_addr[1:0] == 2'(p)) begin
                            st_d.intr[p] = merge(st_q.intr[p], st_q.s_intr, wr_data);
                            st_d.mask[p] = merge(st_q.mask[p], st_q.s_mask, wr_data);
                            st_d.pat1[p] = merge(st_q.pat1[p], st_q.s_pat1, wr_data);
                            st_d.pat0[p] = merge(st_q.pat0[p], st_q.s_pat0, wr_data);
                            st_d.pull[p] = merge(st_q.pull[p], st_q.s_pull, wr_data);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rport == 3'(p)) begin
                case (rfld)
                    FLD_INTR:  rd_data = st_q.intr[p];
                    FLD_MASK:  rd_data = st_q.mask[p];
                    FLD_PAT1:  rd_data = st_q.pat1[p];
                    FLD_PAT0:  rd_data = st_q.pat0[p];
                    FLD_PULL:  rd_data = st_q.pull[p];
                    FLD_FLAG:  rd_data = st_q.flag[p];
                    FLD_LEVEL: rd_data = lvl[p];
                    default:   rd_data = '0;
                endcase
            end
        end
        if (rport == SHADOW_PORT) begin
            case (rfld)
                FLD_INTR: rd_data = st_q.s_intr;
                FLD_MASK: rd_data = st_q.s_mask;
                FLD_PAT1: rd_data = st_q.s_pat1;
                FLD_PAT0: rd_data = st_q.s_pat0;
                FLD_PULL: rd_data = st_q.s_pull;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_port_ctrl_chk
    import gpio_pkg::*;
#(
    parameter  int NUM_PORTS = 4,
    parameter  int PIN_W     = 32,
    localparam int TOTAL     = NUM_PORTS * PIN_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [PIN_W-1:0]                wr_data,
    input logic [NUM_PORTS-1:0][PIN_W-1:0] pad_oe_v,
    input logic [NUM_PORTS-1:0][PIN_W-1:0] intr_q,
    input logic [NUM_PORTS-1:0][PIN_W-1:0] mask_q,
    input logic [NUM_PORTS-1:0][PIN_W-1:0] pat1_q,
    input logic [NUM_PORTS-1:0][PIN_W-1:0] flag_q,
    input logic [PIN_W-1:0]                sh_mask
);
    logic [NUM_PORTS-1:0][PIN_W-1:0] clr_v;
    logic                            unmapped_wr;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            clr_v[p] = (wr_en && wr_addr == {3'(p), FLD_FLAG, OP_CLR}) ? wr_data : '0;
        end
    end

    assign unmapped_wr = wr_en && (wr_addr[7:5] >= 3'(NUM_PORTS)) &&
                         (wr_addr[7:5] != SHADOW_PORT);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_load_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == {SHADOW_PORT, FLD_LOAD, 2'(p)}) |=>
            (((mask_q[p] & $past(wr_data)) == ($past(sh_mask) & $past(wr_data))) &&
             ((mask_q[p] & ~$past(wr_data)) == ($past(mask_q[p]) & ~$past(wr_data)))));

        assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ((($past(flag_q[p]) & ~$past(clr_v[p])) & ~flag_q[p]) == '0));

        assert_no_stray_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((pad_oe_v[p] & (intr_q[p] | (mask_q[p] & pat1_q[p]))) == '0));

        assert_flag_needs_intr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((flag_q[p] & ~$past(flag_q[p]) & ~$past(intr_q[p])) == '0));
    end

    assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_wr |=> ($stable(mask_q) && $stable(intr_q) && $stable(pat1_q)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PIN_W     (PIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pad_oe_v (pad_oe),
    .intr_q   (st_q.intr),
    .mask_q   (st_q.mask),
    .pat1_q   (st_q.pat1),
    .flag_q   (st_q.flag),
    .sh_mask  (st_q.s_mask)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
    localparam int NP    = 4;
    localparam int PW    = 32;
    localparam int TOTAL = NP * PW;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [7:0]        wr_addr;
    logic [PW-1:0]     wr_data;
    logic [7:0]        rd_addr;
    logic [PW-1:0]     rd_data;
    logic [TOTAL-1:0]  pad_di, pad_do, pad_oe, pad_pu;
    logic [4*TOTAL-1:0] dev_do, dev_oe;
    logic [NP-1:0]     port_irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctrl #(.NUM_PORTS(NP), .PIN_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .dev_do(dev_do), .dev_oe(dev_oe), .port_irq(port_irq)
    );

    function automatic logic [7:0] A(input int port, input int fld, input int op);
        A = {3'(port), 3'(fld), 2'(op)};
    endfunction

    function automatic logic [31:0] ddo(input int f, input int p);
        ddo = 32'(32'h9E37_79B9 * (f * 4 + p + 1));
    endfunction

    function automatic logic [31:0] doe(input int f, input int p);
        doe = ddo(f, p) ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] exp_oe(input int c, input int p);
        if (c[3] == 0 && c[2] == 0)      exp_oe = doe(c & 3, p);
        else if (c[3] == 0 && c[1] == 0) exp_oe = ONES;
        else                             exp_oe = '0;
    endfunction

    function automatic logic [31:0] exp_do(input int c, input int p);
        if (c[3] == 0 && c[2] == 0)      exp_do = ddo(c & 3, p);
        else if (c[3] == 0 && c[1] == 0) exp_do = c[0] ? ONES : '0;
        else                             exp_do = '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic set_shadow(input int c);
        // field order: intr <- c[3], mask <- c[2], pat1 <- c[1], pat0 <- c[0], pull <- c[4]
        wr(A(7, 0, c[3] ? 1 : 2), ONES);
        wr(A(7, 1, c[2] ? 1 : 2), ONES);
        wr(A(7, 2, c[1] ? 1 : 2), ONES);
        wr(A(7, 3, c[0] ? 1 : 2), ONES);
        wr(A(7, 4, c[4] ? 1 : 2), ONES);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        pad_di = '0;
        for (int f = 0; f < 4; f++) begin
            for (int p = 0; p < NP; p++) begin
                dev_do[f*TOTAL + p*PW +: PW] = ddo(f, p);
                dev_oe[f*TOTAL + p*PW +: PW] = doe(f, p);
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A(0, 1, 0), v); chk("R1 mask", v, ONES);
        rd(A(2, 2, 0), v); chk("R1 pat1", v, ONES);
        rd(A(3, 4, 0), v); chk("R1 pull", v, ONES);
        rd(A(1, 0, 0), v); chk("R1 intr", v, '0);
        rd(A(1, 3, 0), v); chk("R1 pat0", v, '0);
        rd(A(0, 5, 0), v); chk("R1 flag", v, '0);
        for (int p = 0; p < NP; p++) begin
            chk("R1 pad_oe", pad_oe[p*PW +: PW], '0);
            chk("R1 pad_pu", pad_pu[p*PW +: PW], ONES);
        end
        chk("R1 port_irq", 32'(port_irq), '0);

        // R5 set / clear / no-op operations
        wr(A(3, 3, 1), 32'h0000_0011);
        rd(A(3, 3, 0), v); chk("R5 set", v, 32'h0000_0011);
        wr(A(3, 3, 0), 32'h0000_00FF);
        rd(A(3, 3, 0), v); chk("R5 op0 ignored", v, 32'h0000_0011);
        wr(A(3, 3, 3), 32'h0000_00FF);
        rd(A(3, 3, 0), v); chk("R5 op3 ignored", v, 32'h0000_0011);
        wr(A(3, 3, 2), 32'h0000_0001);
        rd(A(3, 3, 0), v); chk("R5 clear", v, 32'h0000_0010);
        wr(A(1, 4, 2), 32'h0F0F_0F0F);
        rd(A(1, 4, 0), v); chk("R5 pull clear", v, 32'hF0F0_F0F0);
        chk("R4 pad_pu follows pull", pad_pu[PW +: PW], 32'hF0F0_F0F0);

        // R12 unmapped ports
        wr(A(5, 4, 2), ONES);
        wr(A(5, 1, 2), ONES);
        rd(A(5, 4, 0), v); chk("R12 read zero", v, '0);
        rd(A(0, 4, 0), v); chk("R12 port0 pull", v, ONES);
        rd(A(2, 1, 0), v); chk("R12 port2 mask", v, ONES);

        // R6 synchronized level read
        pad_di[PW +: PW] = 32'h1234_5678;
        @(negedge clk);
        rd(A(1, 6, 0), v); chk("R6 one edge", v, '0);
        @(negedge clk);
        rd(A(1, 6, 0), v); chk("R6 two edges", v, 32'h1234_5678);
        wr(A(1, 6, 2), ONES);
        rd(A(1, 6, 0), v); chk("R6 write ignored", v, 32'h1234_5678);
        pad_di = '0;
        repeat (3) @(negedge clk);

        // R2 R3 R4 R7 sweep of every code on every port
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 32; c++) begin
                set_shadow(c);
                wr(A(7, 7, p), ONES);
                chk("R2/R3/R4 pad_oe", pad_oe[p*PW +: PW], exp_oe(c, p));
                chk("R2/R3 pad_do", pad_do[p*PW +: PW], exp_do(c, p));
                chk("R4 pad_pu", pad_pu[p*PW +: PW], c[4] ? ONES : '0);
            end
        end

        // R7 partial load: port 2 pins 4..7 to output-high
        set_shadow(5'h05);
        wr(A(7, 7, 2), 32'h0000_00F0);
        chk("R7 partial oe", pad_oe[2*PW +: PW], 32'h0000_00F0);
        chk("R7 partial do", pad_do[2*PW +: PW], 32'h0000_00F0);
        chk("R7 other port", pad_oe[PW +: PW], '0);
        rd(A(2, 2, 0), v); chk("R7 pat1 merge", v, 32'hFFFF_FF0F);
        rd(A(2, 0, 0), v); chk("R7 intr merge", v, 32'hFFFF_FF0F);
        rd(A(7, 3, 0), v); chk("R7 shadow kept", v, ONES);

        // R8 R9 R10 R11 interrupts on port 3
        for (int p = 0; p < NP; p++) wr(A(p, 5, 2), ONES);
        set_shadow(5'h1F); wr(A(7, 7, 3), 32'h1);
        set_shadow(5'h1D); wr(A(7, 7, 3), 32'h2);
        set_shadow(5'h1E); wr(A(7, 7, 3), 32'h4);
        wr(A(3, 5, 2), ONES);
        rd(A(3, 5, 0), v); chk("R10 flags cleared", v, '0);
        chk("R11 irq idle", 32'(port_irq), '0);

        pad_di[3*PW +: PW] = 32'h7;
        repeat (4) @(negedge clk);
        rd(A(3, 5, 0), v); chk("R8/R9 rise flags", v, 32'h3);
        chk("R11 masked", 32'(port_irq), '0);
        wr(A(3, 1, 2), 32'h1);
        chk("R11 enabled", 32'(port_irq), 32'h8);
        wr(A(3, 5, 2), 32'h3);
        rd(A(3, 5, 0), v); chk("R10 set wins over clear", v, 32'h2);
        chk("R11 after clear", 32'(port_irq), '0);
        wr(A(3, 5, 1), 32'h4);
        rd(A(3, 5, 0), v); chk("R10 op1 ignored", v, 32'h2);

        pad_di[3*PW +: PW] = '0;
        repeat (4) @(negedge clk);
        rd(A(3, 5, 0), v); chk("R9 fall flags", v, 32'h6);
        wr(A(3, 5, 2), 32'h7);
        repeat (2) @(negedge clk);
        rd(A(3, 5, 0), v); chk("R8 level inactive", v, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule